// File: doc/BRIEF.md
# Fixed-Length Instruction Decoder with Legality Checking

This block takes one 32-bit instruction word, together with the address it was fetched from, and turns it into everything a later pipeline stage needs. It splits out the opcode, register fields, shift amount and 16-bit immediate. It produces the immediate both sign-extended and zero-extended. It forms an absolute jump target. It raises one strobe for the class of operation (arithmetic/logic, load, store, branch, register move, system), along with the codes that refine that class. Decoding is purely combinational, so every output belongs to the word present on the inputs in the same cycle.

The decoder also polices the encoding. An opcode outside the defined set is illegal. A shift amount on a non-shift register-format operation is illegal. A register field that the operation does not use must hold the reserved "no register" code (all ones); any other value there is illegal. When the word is illegal, every class strobe and every refining code is forced to zero, so the next stage only has to look at the illegal flag.

The block sits on a valid/ready stream without storing anything. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, in the same cycle. A word is consumed in a cycle where both `in_valid` and `out_ready` are high. Back-pressure from downstream passes straight upstream, and the decoded outputs track whatever word is held on `instr`.

Top module: `instr_decoder`

## Requirements
- R1: `opcode` is instr[31:26] and `rs1` is instr[25:21]. For register-format opcodes, `rs2` is instr[20:16], `rd` is instr[15:11] and `shamt` is instr[10:6]. For immediate-format opcodes, `rd` is instr[20:16], `rs2` reads 31 and `shamt` reads 0.
- R2: `imm_sext` is instr[15:0] sign-extended to 32 bits, and `imm_zext` is instr[15:0] zero-extended, for every opcode.
- R3: `jump_target` equals {pc[31:28], instr[25:0], 2'b00} for every word.
- R4: `fmt` is 1 (immediate) for opcodes 0x03–0x13, 0x22, 0x25 and 0x26. It is 0 (register) for 0x00–0x02, 0x14–0x21, 0x23–0x24 and every opcode above 0x26. Code 2 is reserved for the absolute-jump format, which no current opcode uses.
- R5: A nonzero `shamt` on a register-format opcode other than 0x17 or 0x18 sets `illegal`.
- R6: Register-field use is as follows:
  - Nothing for 0x00, 0x22, 0x23, 0x24.
  - rs1 only for 0x0D–0x13.
  - rd only for 0x0B, 0x0C.
  - rs1 and rs2 for 0x14.
  - rs1 and rd for 0x01–0x0A, 0x15, 0x16, 0x1D, 0x25, 0x26.
  - rs1 and rd for 0x17 and 0x18; rs2 is left unchecked for these two.
  - All three for 0x19–0x1C and 0x1E–0x21.

  Any field that is not used and does not read 31 sets `illegal`.
- R7: Every opcode above 0x26 sets `illegal`.
- R8: At most one of `alu_en`, `load_en`, `store_en`, `branch_en`, `move_en`, `sys_en` is high, and all are low when `illegal` is high. Classes:
  - ALU: 0x14–0x21, 0x25, 0x26.
  - Load: 0x03–0x07.
  - Store: 0x08–0x0A.
  - Branch: 0x0D–0x13.
  - Move: 0x01, 0x02, 0x0B, 0x0C.
  - System: 0x22–0x24.
- R9: `alu_op` is 0 unless `alu_en` is high. Otherwise the code is:
  - add 0 (0x19, 0x25)
  - subtract 1 (0x1A, 0x26)
  - and 2
  - or 3
  - xor 4
  - nand 5
  - nor 6
  - xnor 7
  - not 8
  - shift-left 9
  - shift-right 10
  - increment 11
  - decrement 12
  - compare 13
- R10: `mem_size` and `mem_signed` are 0 unless a load or store strobe is high. Sizes are byte 0, half 1, word 2. `mem_signed` is high only for 0x04 and 0x06.
- R11: `branch_cond` is 0 unless `branch_en` is high; otherwise it is the opcode minus 0x0D.
- R12: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Upstream may advance (mirrors out_ready) |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction word |
| out_valid | output | 1 | Decoded bundle present (mirrors in_valid) |
| out_ready | input | 1 | Downstream accepts the bundle |
| fmt | output | 2 | Format code: 0 register, 1 immediate, 2 absolute jump |
| opcode | output | 6 | Opcode field |
| rs1 | output | 5 | First source register |
| rs2 | output | 5 | Second source register (31 for immediate format) |
| rd | output | 5 | Destination register |
| shamt | output | 5 | Shift amount (0 for immediate format) |
| imm_sext | output | 32 | Sign-extended immediate |
| imm_zext | output | 32 | Zero-extended immediate |
| jump_target | output | 32 | Absolute target built from the word and pc |
| alu_en | output | 1 | Arithmetic/logic operation |
| alu_op | output | 4 | ALU operation code |
| load_en | output | 1 | Memory load |
| store_en | output | 1 | Memory store |
| mem_size | output | 2 | Access size |
| mem_signed | output | 1 | Load result sign-extended |
| branch_en | output | 1 | Conditional or unconditional jump |
| branch_cond | output | 3 | Jump condition code |
| move_en | output | 1 | Register copy or literal load |
| sys_en | output | 1 | Interrupt, interrupt return or halt |
| illegal | output | 1 | Encoding rejected |

## Verification
Every result of this block is due in the same cycle that its word and pc are applied, because there are no registers on any path. The bench therefore changes the inputs shortly after a rising edge and compares every output against its own model at the following falling edge. By then all combinational settling is complete, and the next input change is still half a period away. The handshake mirrors are checked at the same sample point, under independently toggled valid and ready, so back-pressure is seen to pass through with zero delay.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 16;
  localparam int ADDR_W = 26;
  localparam logic [REG_W-1:0] NOREG = '1;

  localparam logic [OPC_W-1:0] OP_NOP  = 6'h00, OP_MOV  = 6'h01, OP_MOVS = 6'h02;
  localparam logic [OPC_W-1:0] OP_LDB  = 6'h03, OP_LDBS = 6'h04, OP_LDH  = 6'h05;
  localparam logic [OPC_W-1:0] OP_LDHS = 6'h06, OP_LDW  = 6'h07, OP_STB  = 6'h08;
  localparam logic [OPC_W-1:0] OP_STH  = 6'h09, OP_STW  = 6'h0A, OP_LLI  = 6'h0B;
  localparam logic [OPC_W-1:0] OP_LUI  = 6'h0C, OP_JMP  = 6'h0D, OP_JLE  = 6'h13;
  localparam logic [OPC_W-1:0] OP_CMP  = 6'h14, OP_INC  = 6'h15, OP_DEC  = 6'h16;
  localparam logic [OPC_W-1:0] OP_SHL  = 6'h17, OP_SHR  = 6'h18, OP_ADD  = 6'h19;
  localparam logic [OPC_W-1:0] OP_SUB  = 6'h1A, OP_AND  = 6'h1B, OP_OR   = 6'h1C;
  localparam logic [OPC_W-1:0] OP_NOT  = 6'h1D, OP_XOR  = 6'h1E, OP_NAND = 6'h1F;
  localparam logic [OPC_W-1:0] OP_NOR  = 6'h20, OP_XNOR = 6'h21, OP_INT  = 6'h22;
  localparam logic [OPC_W-1:0] OP_IRT  = 6'h23, OP_HLT  = 6'h24, OP_IADD = 6'h25;
  localparam logic [OPC_W-1:0] OP_ISUB = 6'h26;
  localparam logic [OPC_W-1:0] OP_LAST = OP_ISUB;

  typedef enum logic [1:0] {FMT_R = 2'd0, FMT_I = 2'd1, FMT_J = 2'd2} fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_NAND = 4'd5, ALU_NOR = 4'd6, ALU_XNOR = 4'd7,
    ALU_NOT = 4'd8, ALU_SHL = 4'd9, ALU_SHR = 4'd10, ALU_INC = 4'd11,
    ALU_DEC = 4'd12, ALU_CMP = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} msize_e;

  typedef struct packed {
    fmt_e        fmt;
    logic        known;
    logic        use_rs1;
    logic        use_rs2;
    logic        use_rd;
    logic        shift_ok;
    logic        alu_en;
    alu_op_e     alu_op;
    logic        load_en;
    logic        store_en;
    msize_e      msize;
    logic        msign;
    logic        br_en;
    logic [2:0]  br_cond;
    logic        move_en;
    logic        sys_en;
  } ctl_t;
endpackage

// File: rtl/opcode_table.sv
module opcode_table
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '0;
    ctl.fmt = FMT_R;
    ctl.known = (opc <= OP_LAST);
    case (opc)
      OP_NOP: ;
      OP_MOV, OP_MOVS: begin
        ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.move_en = 1'b1;
      end
      OP_LDB, OP_LDBS, OP_LDH, OP_LDHS, OP_LDW: begin
        ctl.fmt = FMT_I; ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.load_en = 1'b1;
        ctl.msign = (opc == OP_LDBS) || (opc == OP_LDHS);
        ctl.msize = (opc == OP_LDW) ? SZ_WORD :
                    ((opc == OP_LDH) || (opc == OP_LDHS)) ? SZ_HALF : SZ_BYTE;
      end
      OP_STB, OP_STH, OP_STW: begin
        ctl.fmt = FMT_I; ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.store_en = 1'b1;
        ctl.msize = (opc == OP_STW) ? SZ_WORD : (opc == OP_STH) ? SZ_HALF : SZ_BYTE;
      end
      OP_LLI, OP_LUI: begin
        ctl.fmt = FMT_I; ctl.use_rd = 1'b1; ctl.move_en = 1'b1;
      end
      OP_INT: begin
        ctl.fmt = FMT_I; ctl.sys_en = 1'b1;
      end
      OP_IRT, OP_HLT: ctl.sys_en = 1'b1;
      OP_IADD, OP_ISUB: begin
        ctl.fmt = FMT_I; ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.alu_en = 1'b1;
        ctl.alu_op = (opc == OP_IADD) ? ALU_ADD : ALU_SUB;
      end
      OP_CMP: begin
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.alu_en = 1'b1; ctl.alu_op = ALU_CMP;
      end
      OP_INC, OP_DEC, OP_NOT: begin
        ctl.use_rs1 = 1'b1; ctl.use_rd = 1'b1; ctl.alu_en = 1'b1;
        ctl.alu_op = (opc == OP_INC) ? ALU_INC : (opc == OP_DEC) ? ALU_DEC : ALU_NOT;
      end
      OP_SHL, OP_SHR: begin
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.use_rd = 1'b1;
        ctl.shift_ok = 1'b1; ctl.alu_en = 1'b1;
        ctl.alu_op = (opc == OP_SHL) ? ALU_SHL : ALU_SHR;
      end
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR: begin
        ctl.use_rs1 = 1'b1; ctl.use_rs2 = 1'b1; ctl.use_rd = 1'b1; ctl.alu_en = 1'b1;
        case (opc)
          OP_ADD:  ctl.alu_op = ALU_ADD;
          OP_SUB:  ctl.alu_op = ALU_SUB;
          OP_AND:  ctl.alu_op = ALU_AND;
          OP_OR:   ctl.alu_op = ALU_OR;
          OP_XOR:  ctl.alu_op = ALU_XOR;
          OP_NAND: ctl.alu_op = ALU_NAND;
          OP_NOR:  ctl.alu_op = ALU_NOR;
          default: ctl.alu_op = ALU_XNOR;
        endcase
      end
      default: begin
        if (opc >= OP_JMP && opc <= OP_JLE) begin
          ctl.fmt = FMT_I; ctl.use_rs1 = 1'b1; ctl.br_en = 1'b1;
          ctl.br_cond = 3'(opc - OP_JMP);
        end
      end
    endcase
  end
endmodule

// File: rtl/field_split.sv
module field_split
  import instr_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  pc,
  input  fmt_e             fmt,
  output logic [OPC_W-1:0] opc,
  output logic [REG_W-1:0] rs1,
  output logic [REG_W-1:0] rs2,
  output logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] shamt,
  output logic [XLEN-1:0]  imm_s,
  output logic [XLEN-1:0]  imm_z,
  output logic [XLEN-1:0]  jtgt
);
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RS1_LSB = OPC_LSB - REG_W;
  localparam int RS2_LSB = RS1_LSB - REG_W;
  localparam int RD_LSB  = RS2_LSB - REG_W;
  localparam int SH_LSB  = RD_LSB - REG_W;
  localparam int EXT_W   = XLEN - IMM_W;
  localparam int TOP_W   = XLEN - ADDR_W - 2;

  logic [IMM_W-1:0] imm_raw;
  logic             is_r;

  assign is_r    = (fmt == FMT_R);
  assign imm_raw = instr[IMM_W-1:0];
  assign opc     = instr[XLEN-1 -: OPC_W];
  assign rs1     = instr[RS1_LSB +: REG_W];
  assign rs2     = is_r ? instr[RS2_LSB +: REG_W] : NOREG;
  assign rd      = is_r ? instr[RD_LSB +: REG_W] : instr[RS2_LSB +: REG_W];
  assign shamt   = is_r ? instr[SH_LSB +: REG_W] : '0;
  assign imm_s   = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
  assign imm_z   = {{EXT_W{1'b0}}, imm_raw};
  assign jtgt    = {pc[XLEN-1 -: TOP_W], instr[ADDR_W-1:0], 2'b00};
endmodule

// File: rtl/legality_check.sv
module legality_check
  import instr_dec_pkg::*;
(
  input  ctl_t             ctl,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] shamt,
  output logic             illegal
);
  logic bad_shift, bad_regs;

  assign bad_shift = (ctl.fmt == FMT_R) && !ctl.shift_ok && (shamt != '0);
  assign bad_regs  = (!ctl.use_rs1 && rs1 != NOREG) ||
                     (!ctl.use_rs2 && rs2 != NOREG) ||
                     (!ctl.use_rd  && rd  != NOREG);
  assign illegal   = !ctl.known || bad_shift || bad_regs;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       fmt,
  output logic [OPC_W-1:0] opcode,
  output logic [REG_W-1:0] rs1,
  output logic [REG_W-1:0] rs2,
  output logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] shamt,
  output logic [XLEN-1:0]  imm_sext,
  output logic [XLEN-1:0]  imm_zext,
  output logic [XLEN-1:0]  jump_target,
  output logic             alu_en,
  output logic [3:0]       alu_op,
  output logic             load_en,
  output logic             store_en,
  output logic [1:0]       mem_size,
  output logic             mem_signed,
  output logic             branch_en,
  output logic [2:0]       branch_cond,
  output logic             move_en,
  output logic             sys_en,
  output logic             illegal
);
  ctl_t ctl;
  logic ok;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  opcode_table u_table (.opc(instr[XLEN-1 -: OPC_W]), .ctl(ctl));

  field_split #(.XLEN(XLEN)) u_fields (
    .instr(instr), .pc(pc), .fmt(ctl.fmt), .opc(opcode),
    .rs1(rs1), .rs2(rs2), .rd(rd), .shamt(shamt),
    .imm_s(imm_sext), .imm_z(imm_zext), .jtgt(jump_target)
  );

  legality_check u_legal (
    .ctl(ctl), .rs1(rs1), .rs2(rs2), .rd(rd), .shamt(shamt), .illegal(illegal)
  );

  assign ok          = !illegal;
  assign fmt         = ctl.fmt;
  assign alu_en      = ok & ctl.alu_en;
  assign alu_op      = ok ? ctl.alu_op : '0;
  assign load_en     = ok & ctl.load_en;
  assign store_en    = ok & ctl.store_en;
  assign mem_size    = ok ? ctl.msize : '0;
  assign mem_signed  = ok & ctl.msign;
  assign branch_en   = ok & ctl.br_en;
  assign branch_cond = ok ? ctl.br_cond : '0;
  assign move_en     = ok & ctl.move_en;
  assign sys_en      = ok & ctl.sys_en;

  always_comb begin
    // R7
    undefined_opcode_chk: assert (!(opcode > OP_LAST) || illegal)
      else $display("assertion: undefined opcode not rejected");
    // R5
    stray_shift_chk: assert (!(fmt == FMT_R && shamt != '0 && opcode != OP_SHL &&
                               opcode != OP_SHR) || illegal)
      else $display("assertion: stray shift amount not rejected");
    // R8
    one_class_chk: assert ($onehot0({alu_en, load_en, store_en, branch_en, move_en, sys_en}))
      else $display("assertion: more than one class strobe");
    // R6
    unused_rd_chk: assert (illegal || ctl.use_rd || rd == NOREG)
      else $display("assertion: unused destination field accepted");
  end
endmodule

// File: tb/test_instr_decoder.sv
module test_instr_decoder;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic in_valid = 0, out_ready = 0, in_ready, out_valid;
  logic [31:0] instr = 0, pc = 0;
  logic [1:0] fmt, mem_size;
  logic [5:0] opcode;
  logic [4:0] rs1, rs2, rd, shamt;
  logic [31:0] imm_sext, imm_zext, jump_target;
  logic alu_en, load_en, store_en, mem_signed, branch_en, move_en, sys_en, illegal;
  logic [3:0] alu_op;
  logic [2:0] branch_cond;

  int checks = 0, fails = 0;

  instr_decoder i_instr_decoder (
    .in_valid(in_valid), .in_ready(in_ready), .instr(instr), .pc(pc),
    .out_valid(out_valid), .out_ready(out_ready), .fmt(fmt), .opcode(opcode),
    .rs1(rs1), .rs2(rs2), .rd(rd), .shamt(shamt), .imm_sext(imm_sext),
    .imm_zext(imm_zext), .jump_target(jump_target), .alu_en(alu_en), .alu_op(alu_op),
    .load_en(load_en), .store_en(store_en), .mem_size(mem_size), .mem_signed(mem_signed),
    .branch_en(branch_en), .branch_cond(branch_cond), .move_en(move_en),
    .sys_en(sys_en), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (instr %h)", tag, what, act, exp, instr);
    end
  endtask

  // Behavioural reference, built from the requirement text.
  task automatic compare();
    int op = int'(instr[31:26]);
    bit r_fmt = (op <= 2) || (op >= 20 && op <= 33) || op == 35 || op == 36 || op > 38;
    logic [4:0] e_rs2 = r_fmt ? instr[20:16] : 5'd31;
    logic [4:0] e_rd = r_fmt ? instr[15:11] : instr[20:16];
    logic [4:0] e_sh = r_fmt ? instr[10:6] : 5'd0;
    bit u1, u2, ud, bad, is_shift;
    bit c_alu, c_ld, c_st, c_br, c_mv, c_sys;
    int aop, msz, msg, bc;
    is_shift = (op == 23 || op == 24);
    u1 = !(op == 0 || op == 11 || op == 12 || (op >= 34 && op <= 36) || op > 38);
    ud = (op >= 1 && op <= 12) || (op >= 21 && op <= 33 && op != 20) || op == 37 || op == 38;
    ud = ud && op != 20;
    u2 = (op >= 20 && op <= 33 && op != 21 && op != 22 && op != 29);
    bad = op > 38 || (r_fmt && e_sh != 0 && !is_shift) ||
          (!u1 && instr[25:21] != 5'd31) || (!u2 && e_rs2 != 5'd31) ||
          (!ud && e_rd != 5'd31);
    c_alu = !bad && ((op >= 20 && op <= 33) || op == 37 || op == 38);
    c_ld  = !bad && op >= 3 && op <= 7;
    c_st  = !bad && op >= 8 && op <= 10;
    c_br  = !bad && op >= 13 && op <= 19;
    c_mv  = !bad && (op == 1 || op == 2 || op == 11 || op == 12);
    c_sys = !bad && op >= 34 && op <= 36;
    case (op)
      26, 38: aop = 1;  27: aop = 2;  28: aop = 3;  30: aop = 4;  31: aop = 5;
      32: aop = 6;  33: aop = 7;  29: aop = 8;  23: aop = 9;  24: aop = 10;
      21: aop = 11; 22: aop = 12; 20: aop = 13; default: aop = 0;
    endcase
    if (!c_alu) aop = 0;
    msz = c_ld ? (op - 3) / 2 : c_st ? op - 8 : 0;
    msg = (c_ld && (op == 4 || op == 6)) ? 1 : 0;
    bc  = c_br ? op - 13 : 0;

    chk("R1", "opcode", 32'(opcode), 32'(instr[31:26]));
    chk("R1", "rs1", 32'(rs1), 32'(instr[25:21]));
    chk("R1", "rs2", 32'(rs2), 32'(e_rs2));
    chk("R1", "rd", 32'(rd), 32'(e_rd));
    chk("R1", "shamt", 32'(shamt), 32'(e_sh));
    chk("R2", "imm_sext", imm_sext, {{16{instr[15]}}, instr[15:0]});
    chk("R2", "imm_zext", imm_zext, {16'h0, instr[15:0]});
    chk("R3", "jump_target", jump_target, {pc[31:28], instr[25:0], 2'b00});
    chk("R4", "fmt", 32'(fmt), r_fmt ? 0 : 1);
    chk("R5_R6_R7", "illegal", 32'(illegal), 32'(bad));
    chk("R8", "strobes", {26'h0, alu_en, load_en, store_en, branch_en, move_en, sys_en},
        {26'h0, c_alu, c_ld, c_st, c_br, c_mv, c_sys});
    chk("R9", "alu_op", 32'(alu_op), aop);
    chk("R10", "mem_size", 32'(mem_size), msz);
    chk("R10", "mem_signed", 32'(mem_signed), msg);
    chk("R11", "branch_cond", 32'(branch_cond), bc);
    chk("R12", "out_valid", 32'(out_valid), 32'(in_valid));
    chk("R12", "in_ready", 32'(in_ready), 32'(out_ready));
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] p);
    @(posedge clk); #1;
    instr = w; pc = p;
    in_valid = 1'($urandom_range(0, 1));
    out_ready = 1'($urandom_range(0, 1));
    @(negedge clk);
    compare();
  endtask

  function automatic logic [31:0] rw(input int op, input int a, input int b, input int d,
                                     input int s);
    return {6'(op), 5'(a), 5'(b), 5'(d), 5'(s), 6'd0};
  endfunction

  function automatic logic [4:0] pick_reg();
    return ($urandom_range(0, 9) < 6) ? 5'd31 : 5'($urandom_range(0, 31));
  endfunction

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R12 reset state: nothing offered, nothing presented
    chk("R12", "reset out_valid", 32'(out_valid), 0);
    chk("R12", "reset in_ready", 32'(in_ready), 0);
    rst = 1'b0;
    apply(rw(25, 1, 2, 3, 0), 32'hA000_0000);     // R9 legal add
    apply(rw(25, 1, 2, 3, 4), 32'h0);             // R5 stray shift
    apply(rw(23, 1, 31, 3, 5), 32'h0);            // R5 shift allowed
    apply(rw(24, 4, 9, 6, 31), 32'h0);            // R6 shift rs2 free
    apply(rw(0, 31, 31, 31, 0), 32'h0);           // R6 legal nop
    apply(rw(0, 31, 31, 30, 0), 32'h0);           // R6 nop with rd set
    apply(rw(20, 1, 2, 31, 0), 32'h0);            // R9 compare
    apply(rw(20, 1, 2, 7, 0), 32'h0);             // R6 compare with rd
    apply({6'h04, 5'd3, 5'd4, 16'h8001}, 32'h0);  // R10 signed byte load, R2 neg imm
    apply({6'h0A, 5'd3, 5'd4, 16'h7FFF}, 32'h0);  // R10 word store
    apply({6'h0B, 5'd31, 5'd4, 16'h1234}, 32'h0); // R8 literal move
    apply({6'h0B, 5'd2, 5'd4, 16'h1234}, 32'h0);  // R6 literal move rs1 used
    apply({6'h12, 5'd5, 5'd31, 16'hFFF0}, 32'h0); // R11 jlt
    apply({6'h12, 5'd5, 5'd0, 16'hFFF0}, 32'h0);  // R6 jump rd set
    apply({6'h22, 5'd31, 5'd31, 16'h0042}, 32'h0);// R8 interrupt
    apply({6'h27, 26'h3FF_FFFF}, 32'hF000_0000);  // R7 above range, R3 target
    apply({6'h3F, 26'h000_0001}, 32'h5555_5555);  // R7 top opcode, R3
    apply(rw(29, 1, 31, 2, 0), 32'h0);            // R9 not
    apply({6'h26, 5'd1, 5'd2, 16'h0001}, 32'h0);  // R9 immediate subtract, R4
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = {6'($urandom_range(0, 45)), pick_reg(), pick_reg(), pick_reg(),
           ($urandom_range(0, 9) < 7) ? 5'd0 : 5'($urandom_range(0, 31)),
           6'($urandom_range(0, 63))};
      apply(w, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule